// File: doc/BRIEF.md
# Guarded Multi-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by walking a tree of translation tables held in memory. A walk starts from a root table base supplied with the request. The walker takes a 4-bit index from the top of the untranslated part of the address, fetches the selected 64-bit entry through a single read port, and then decides what to do next. Each entry can carry a guard: a short bit string, with its length, that must equal the next address bits. On a match those bits count as translated without reading any table, so a sparse tree can skip whole levels. A non-leaf entry names the next table. A leaf entry names the 4 KB frame. The 12-bit page offset passes through unchanged.

A walk ends in one of two ways. It either returns a physical address, or it returns a fault code that gives the reason. It also reports how many entries were fetched, because the walk time depends on how many levels the guards skipped. A fetch ceiling protects against malformed tables that would otherwise keep the walker busy. The walker has no translation cache, does no permission checks and never writes an entry.

Top module: `gpw_walker`

## Requirements
- R1: After reset the walker is idle. busy, done, fault, mem_req and fetch_count are 0, and fault_code is 0.
- R2: A start pulse while busy is 0 begins a walk. The first fetch address is {root_base, vaddr[31:28], 3'b000}. Each later fetch address is {child base (entry bits [55:23]), next 4 untranslated bits, 3'b000}. mem_req and mem_addr stay unchanged until mem_ack.
- R3: Entry layout is as follows: bit 0 is valid, bit 1 is leaf, bits [6:2] are the guard length, bits [22:7] are the guard (its low bits are used), and bits [63:23] are the base or frame. A valid leaf that completes the walk gives paddr = {entry[50:23], vaddr[11:0]}, fault = 0 and fault_code = 0.
- R4: A guard of length L that matches the next L address bits consumes them without any fetch. fetch_count equals the number of entries read in the walk.
- R5: An entry with valid = 0 ends the walk with fault_code 1. This check outranks every other check.
- R6: A guard length above 16, or above the number of untranslated bits left after the index, ends the walk with fault_code 3. This check outranks the guard comparison.
- R7: A guard that differs from the next address bits ends the walk with fault_code 2.
- R8: A leaf reached while untranslated address bits remain ends the walk with fault_code 4.
- R9: A non-leaf entry that leaves fewer than 4 untranslated bits ends the walk with fault_code 5.
- R10: A non-leaf entry read as the MAX_FETCH-th fetch ends the walk with fault_code 6. fetch_count never exceeds MAX_FETCH.
- R11: done is high for exactly one cycle per walk. Results hold until the next walk completes. A start while busy is ignored. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| vaddr | input | 32 | Virtual address to translate |
| root_base | input | 33 | Root table base (table-aligned address bits) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk ended in a fault |
| fault_code | output | 3 | Fault reason, 0 when no fault |
| paddr | output | 40 | Translated physical address |
| fetch_count | output | 4 | Entries fetched by the last walk |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 40 | Byte address of the requested entry |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 64 | Entry read data |

## Verification
Two things can fall in the same cycle: the completion pulse of one walk, and the acceptance of a new start. Because the walker drops busy in the done cycle, a start presented at that moment must launch the next walk immediately. The bench raises start in exactly the cycle where it sees done. It then checks that the first walk's result was intact in that cycle, and that the second walk completes with its own frame and fetch count. A start raised in the middle of a walk is also checked: it must not disturb the walk, and it must not produce an extra completion.

// File: rtl/gpw_pkg.sv
package gpw_pkg;

    localparam int ENTRY_W = 64;
    localparam int GUARD_W = 16;
    localparam int GLEN_W  = 5;
    localparam int PTR_W   = ENTRY_W - GUARD_W - GLEN_W - 2;

    // Table entry, least significant field last
    typedef struct packed {
        logic [PTR_W-1:0]   ptr;    // child table base or frame number
        logic [GUARD_W-1:0] guard;
        logic [GLEN_W-1:0]  glen;
        logic               leaf;
        logic               valid;
    } gpw_entry_t;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_INVALID    = 3'd1,
        FLT_GUARD      = 3'd2,
        FLT_GLEN       = 3'd3,
        FLT_EARLY_LEAF = 3'd4,
        FLT_NO_BITS    = 3'd5,
        FLT_LIMIT      = 3'd6
    } gpw_fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } gpw_state_e;

endpackage

// File: rtl/gpw_guard_unit.sv
module gpw_guard_unit
    import gpw_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int REM_W = 5
) (
    input  logic [VPN_W-1:0]   vpn_i,
    input  logic [REM_W-1:0]   rem_i,
    input  logic [GLEN_W-1:0]  glen_i,
    input  logic [GUARD_W-1:0] guard_i,
    output logic               len_bad_o,
    output logic               match_o,
    output logic [VPN_W-1:0]   vpn_o,
    output logic [REM_W-1:0]   rem_o
);

    logic [31:0] top_bits;
    logic [31:0] want_bits;

    always_comb begin
        len_bad_o = (int'(glen_i) > GUARD_W) || (int'(glen_i) > int'(rem_i));
        top_bits  = '0;
        want_bits = '0;
        if ((glen_i != '0) && !len_bad_o) begin
            top_bits  = 32'(vpn_i >> (VPN_W - int'(glen_i)));
            want_bits = 32'(guard_i) & ((32'd1 << glen_i) - 32'd1);
        end
        match_o = (top_bits == want_bits);
        vpn_o   = vpn_i << glen_i;
        rem_o   = rem_i - REM_W'(glen_i);
    end

endmodule

// File: rtl/gpw_step_eval.sv
module gpw_step_eval
    import gpw_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int REM_W     = 5,
    parameter int CNT_W     = 4,
    parameter int IDX_W     = 4,
    parameter int MAX_FETCH = 8
) (
    input  gpw_entry_t       entry_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [REM_W-1:0] rem_i,
    input  logic [CNT_W-1:0] count_i,  // fetches including this one
    output gpw_fault_e       fault_o,
    output logic             finish_o,
    output logic [VPN_W-1:0] vpn_o,
    output logic [REM_W-1:0] rem_o
);

    logic len_bad;
    logic match;

    gpw_guard_unit #(
        .VPN_W (VPN_W),
        .REM_W (REM_W)
    ) u_guard (
        .vpn_i     (vpn_i),
        .rem_i     (rem_i),
        .glen_i    (entry_i.glen),
        .guard_i   (entry_i.guard),
        .len_bad_o (len_bad),
        .match_o   (match),
        .vpn_o     (vpn_o),
        .rem_o     (rem_o)
    );

    // Checks in priority order
    always_comb begin
        fault_o = FLT_NONE;
        if (!entry_i.valid) begin
            fault_o = FLT_INVALID;
        end else if (len_bad) begin
            fault_o = FLT_GLEN;
        end else if (!match) begin
            fault_o = FLT_GUARD;
        end else if (entry_i.leaf) begin
            if (rem_o != '0) fault_o = FLT_EARLY_LEAF;
        end else if (int'(rem_o) < IDX_W) begin
            fault_o = FLT_NO_BITS;
        end else if (int'(count_i) >= MAX_FETCH) begin
            fault_o = FLT_LIMIT;
        end
        finish_o = entry_i.valid && entry_i.leaf && (fault_o == FLT_NONE);
    end

endmodule

// File: rtl/gpw_fetch_addr.sv
module gpw_fetch_addr #(
    parameter int TB_W  = 33,
    parameter int IDX_W = 4,
    parameter int ESZ_W = 3,
    parameter int PA_W  = TB_W + IDX_W + ESZ_W
) (
    input  logic [TB_W-1:0]  base_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [PA_W-1:0]  addr_o
);

    // Tables are aligned to their own size: base, index, entry byte offset
    assign addr_o = {base_i, idx_i, {ESZ_W{1'b0}}};

endmodule

// File: rtl/gpw_walker.sv
module gpw_walker
    import gpw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 4,
    parameter int PA_W      = 40,
    parameter int MAX_FETCH = 8,
    localparam int ESZ_W    = $clog2(ENTRY_W / 8),
    localparam int VPN_W    = VA_W - OFF_W,
    localparam int REM_W    = $clog2(VPN_W + 1),
    localparam int TB_W     = PA_W - IDX_W - ESZ_W,
    localparam int FR_W     = PA_W - OFF_W,
    localparam int CNT_W    = $clog2(MAX_FETCH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VA_W-1:0]    vaddr,
    input  logic [TB_W-1:0]    root_base,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [2:0]         fault_code,
    output logic [PA_W-1:0]    paddr,
    output logic [CNT_W-1:0]   fetch_count,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_ack,
    input  logic [ENTRY_W-1:0] mem_rdata
);

    typedef struct packed {
        gpw_state_e       state;
        logic [VPN_W-1:0] vpn;    // untranslated bits, left aligned
        logic [REM_W-1:0] rem;    // untranslated bit count
        logic [PA_W-1:0]  addr;
        logic [OFF_W-1:0] off;
        logic [CNT_W-1:0] count;
        logic             done;
        logic             fault;
        gpw_fault_e       code;
        logic [PA_W-1:0]  paddr;
    } walk_regs_t;

    walk_regs_t q, d;

    gpw_entry_t       ent;
    gpw_fault_e       step_fault;
    logic             step_finish;
    logic [VPN_W-1:0] step_vpn;
    logic [REM_W-1:0] step_rem;
    logic [CNT_W-1:0] cnt_inc;
    logic [TB_W-1:0]  base_sel;
    logic [IDX_W-1:0] idx_sel;
    logic [PA_W-1:0]  fetch_addr;
    logic             unused_ptr;

    assign ent        = gpw_entry_t'(mem_rdata);
    assign cnt_inc    = q.count + CNT_W'(1);
    assign unused_ptr = ^ent.ptr;

    gpw_step_eval #(
        .VPN_W     (VPN_W),
        .REM_W     (REM_W),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W),
        .MAX_FETCH (MAX_FETCH)
    ) u_step (
        .entry_i  (ent),
        .vpn_i    (q.vpn),
        .rem_i    (q.rem),
        .count_i  (cnt_inc),
        .fault_o  (step_fault),
        .finish_o (step_finish),
        .vpn_o    (step_vpn),
        .rem_o    (step_rem)
    );

    // Address source: root on launch, child table while walking
    always_comb begin
        if (q.state == ST_WALK) begin
            base_sel = ent.ptr[TB_W-1:0];
            idx_sel  = step_vpn[VPN_W-1 -: IDX_W];
        end else begin
            base_sel = root_base;
            idx_sel  = vaddr[VA_W-1 -: IDX_W];
        end
    end

    gpw_fetch_addr #(
        .TB_W  (TB_W),
        .IDX_W (IDX_W),
        .ESZ_W (ESZ_W),
        .PA_W  (PA_W)
    ) u_addr (
        .base_i (base_sel),
        .idx_i  (idx_sel),
        .addr_o (fetch_addr)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_WALK;
                    d.vpn   = vaddr[VA_W-1:OFF_W] << IDX_W;
                    d.rem   = REM_W'(VPN_W - IDX_W);
                    d.off   = vaddr[OFF_W-1:0];
                    d.count = '0;
                    d.addr  = fetch_addr;
                end
            end
            ST_WALK: begin
                if (mem_ack) begin
                    d.count = cnt_inc;
                    if (step_fault != FLT_NONE) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b1;
                        d.code  = step_fault;
                        d.paddr = '0;
                    end else if (step_finish) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b0;
                        d.code  = FLT_NONE;
                        d.paddr = {ent.ptr[FR_W-1:0], q.off};
                    end else begin
                        d.addr = fetch_addr;
                        d.vpn  = step_vpn << IDX_W;
                        d.rem  = step_rem - REM_W'(IDX_W);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.state == ST_WALK);
    assign mem_req     = (q.state == ST_WALK);
    assign mem_addr    = q.addr;
    assign done        = q.done;
    assign fault       = q.fault;
    assign fault_code  = q.code;
    assign paddr       = q.paddr;
    assign fetch_count = q.count;

endmodule

// File: rtl/gpw_walker_chk.sv
module gpw_walker_chk #(
    parameter int PA_W      = 40,
    parameter int CNT_W     = 4,
    parameter int MAX_FETCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             fault,
    input logic [2:0]       fault_code,
    input logic [PA_W-1:0]  paddr,
    input logic [CNT_W-1:0] fetch_count,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [PA_W-1:0]  mem_addr
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));          // R2

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));                              // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(paddr) && $stable(fault_code) && $stable(fault))); // R11

    AST_WALK_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                              // R11

    AST_FETCH_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fetch_count) <= MAX_FETCH);                                    // R10

    AST_SUCCESS_FETCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (fetch_count != '0));                          // R4

    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code != 3'd0));                          // R3

endmodule

bind gpw_walker gpw_walker_chk #(
    .PA_W      (PA_W),
    .CNT_W     (CNT_W),
    .MAX_FETCH (MAX_FETCH)
) u_chk (.*);

// File: tb/gpw_walker_test.sv
`timescale 1ns/1ps
module gpw_walker_test;

    localparam int CLK_NS = 20;
    localparam int MAXF   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0;
    logic [32:0] root_base = '0;
    logic        busy, done, fault, mem_req;
    logic [2:0]  fault_code;
    logic [39:0] paddr, mem_addr;
    logic [2:0]  fetch_count;
    logic        mem_ack;
    logic [63:0] mem_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [63:0] mem [logic [39:0]];
    logic [39:0] seen [$];

    always #(CLK_NS/2) clk = ~clk;

    gpw_walker #(.MAX_FETCH(MAXF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
        .root_base(root_base), .busy(busy), .done(done), .fault(fault),
        .fault_code(fault_code), .paddr(paddr), .fetch_count(fetch_count),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // One-cycle latency entry memory
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
            seen.push_back(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [39:0] taddr(logic [32:0] b, logic [3:0] i);
        return {b, i, 3'b000};
    endfunction

    function automatic logic [63:0] ent(bit v, bit lf, logic [4:0] gl,
                                        logic [15:0] g, logic [40:0] p);
        return {p, g, gl, lf, v};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(logic [31:0] va, logic [32:0] rb);
        @(negedge clk);
        vaddr = va; root_base = rb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done && k < 200) begin
            @(negedge clk);
            k++;
        end
        if (!done) chk("R11 walk completes", 0, 1);
    endtask

    task automatic expect_walk(string req, logic [2:0] code,
                               logic [39:0] pa, logic [2:0] cnt);
        chk({req, " fault_code"}, 64'(fault_code), 64'(code));
        chk({req, " fault"}, 64'(fault), 64'(code != 3'd0));
        chk({req, " fetch_count"}, 64'(fetch_count), 64'(cnt));
        if (code == 3'd0) chk({req, " paddr"}, 64'(paddr), 64'(pa));
    endtask

    task automatic walk(string req, logic [31:0] va, logic [32:0] rb,
                        logic [2:0] code, logic [39:0] pa, logic [2:0] cnt);
        seen.delete();
        launch(va, rb);
        wait_done();
        expect_walk(req, code, pa, cnt);
    endtask

    // Four-level tree for VA 1234_5ABC, last level guard on nibble 5
    task automatic build_deep(bit fifth);
        mem.delete();
        mem[taddr(33'h10, 4'h1)] = ent(1, 0, 0, 0, 41'h20);
        mem[taddr(33'h20, 4'h2)] = ent(1, 0, 0, 0, 41'h30);
        mem[taddr(33'h30, 4'h3)] = ent(1, 0, 0, 0, 41'h40);
        if (fifth) begin
            mem[taddr(33'h40, 4'h4)] = ent(1, 0, 0, 0, 41'h50);
            mem[taddr(33'h50, 4'h5)] = ent(1, 1, 0, 0, 41'h00ABCDE);
        end else begin
            mem[taddr(33'h40, 4'h4)] = ent(1, 1, 4, 16'h5, 41'h00ABCDE);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 mem_req", 64'(mem_req), 0);
        chk("R1 fault", 64'(fault), 0);
        chk("R1 fault_code", 64'(fault_code), 0);
        chk("R1 fetch_count", 64'(fetch_count), 0);
    endtask

    task automatic t_deep();
        build_deep(0);
        walk("R3 deep leaf", 32'h1234_5ABC, 33'h10, 3'd0, 40'h00ABCDEABC, 3'd4);
        chk("R2 first fetch addr", 64'(seen[0]), 64'(taddr(33'h10, 4'h1)));
        chk("R2 second fetch addr", 64'(seen[1]), 64'(taddr(33'h20, 4'h2)));
        chk("R2 fourth fetch addr", 64'(seen[3]), 64'(taddr(33'h40, 4'h4)));
    endtask

    task automatic t_skip();
        mem.delete();
        mem[taddr(33'h10, 4'h1)] = ent(1, 0, 12, 16'h234, 41'h60);
        mem[taddr(33'h60, 4'h5)] = ent(1, 1, 0, 0, 41'h1111);
        walk("R4 guard skip", 32'h1234_5ABC, 33'h10, 3'd0, 40'h0001111ABC, 3'd2);
        chk("R4 skip fetch addr", 64'(seen[1]), 64'(taddr(33'h60, 4'h5)));
        mem.delete();
        mem[taddr(33'h10, 4'h9)] = ent(1, 1, 16, 16'h8765, 41'h77);
        walk("R4 root leaf", 32'h9876_5432, 33'h10, 3'd0, 40'h0000077432, 3'd1);
    endtask

    task automatic t_faults();
        mem.delete();
        walk("R5 invalid", 32'h1234_5ABC, 33'h10, 3'd1, 0, 3'd1);
        mem[taddr(33'h10, 4'h1)] = ent(0, 1, 5'd31, 16'hFFFF, 41'h1);
        walk("R5 invalid outranks", 32'h1234_5ABC, 33'h10, 3'd1, 0, 3'd1);
        mem[taddr(33'h10, 4'h1)] = ent(1, 0, 8, 16'h24, 41'h60);
        walk("R7 guard mismatch", 32'h1234_5ABC, 33'h10, 3'd2, 0, 3'd1);
        mem[taddr(33'h10, 4'h1)] = ent(1, 0, 17, 16'h0, 41'h60);
        walk("R6 glen over 16", 32'h1234_5ABC, 33'h10, 3'd3, 0, 3'd1);
        mem[taddr(33'h10, 4'h1)] = ent(1, 0, 12, 16'h234, 41'h60);
        mem[taddr(33'h60, 4'h5)] = ent(1, 1, 1, 16'h0, 41'h1);
        walk("R6 glen over remaining", 32'h1234_5ABC, 33'h10, 3'd3, 0, 3'd2);
        mem[taddr(33'h10, 4'h1)] = ent(1, 1, 0, 16'h0, 41'h5);
        walk("R8 early leaf", 32'h1234_5ABC, 33'h10, 3'd4, 0, 3'd1);
        mem[taddr(33'h10, 4'h1)] = ent(1, 0, 16, 16'h2345, 41'h60);
        walk("R9 no index bits", 32'h1234_5ABC, 33'h10, 3'd5, 0, 3'd1);
        build_deep(1);
        walk("R10 fetch limit", 32'h1234_5ABC, 33'h10, 3'd6, 0, 3'd4);
    endtask

    task automatic t_busy_start();
        build_deep(0);
        launch(32'h1234_5ABC, 33'h10);
        @(negedge clk);
        vaddr = 32'hF000_0000; root_base = 33'h99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        expect_walk("R11 start while busy ignored", 3'd0, 40'h00ABCDEABC, 3'd4);
        repeat (4) begin
            @(negedge clk);
            chk("R11 no extra walk busy", 64'(busy), 0);
            chk("R11 no extra done", 64'(done), 0);
        end
    endtask

    task automatic t_back_to_back();
        mem.delete();
        mem[taddr(33'h10, 4'h9)] = ent(1, 1, 16, 16'h8765, 41'h77);
        mem[taddr(33'h10, 4'h1)] = ent(1, 0, 12, 16'h234, 41'h60);
        mem[taddr(33'h60, 4'h5)] = ent(1, 1, 0, 0, 41'h1111);
        launch(32'h9876_5432, 33'h10);
        wait_done();
        // Same cycle as done: first result visible, new start presented
        expect_walk("R11 first of pair", 3'd0, 40'h0000077432, 3'd1);
        vaddr = 32'h1234_5ABC; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 start in done cycle accepted", 64'(busy), 1);
        wait_done();
        expect_walk("R11 second of pair", 3'd0, 40'h0001111ABC, 3'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_deep();
        t_skip();
        t_faults();
        t_busy_start();
        t_back_to_back();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule